// File: doc/BRIEF.md
# Write-Only Two-Wire Control Register Target

This block is a target on a two-wire serial control bus (I2C). It accepts write transfers only and loads a small bank of 8-bit control registers. Those registers drive the rest of the chip through parallel outputs. Each register that gets written raises a one-cycle strobe together with that register's index.

The serial clock and data pins are sampled in the system clock domain through a short synchronizer, and their edges are detected there. For that reason the system clock must run at least about eight times faster than the serial clock. The target pulls the data line low through an open-drain enable to acknowledge a byte. A strap input sets the lowest bit of the device address, so two of these targets can share one bus.

A transfer starts with a START condition, then an address byte, then a register-select byte. After that come any number of data bytes. A pointer steps through the bank after each data byte and wraps from the last register back to the first. A read request is rejected without any reply.

Top module: `i2c_wr_target`

## Requirements
- R1: Reset clears every register to 00h, releases the data line (sdaPullLow = 0) and keeps wrStrobe low.
- R2: After a START, the address byte arrives MSB first as seven address bits followed by a direction bit. Address bits 7..2 must be 001000 and bit 1 must equal strapBit. With direction bit 0, the target pulls SDA low for the whole high phase of the ninth clock. Pull-down begins only while SCL is low.
- R3: An address byte whose fixed bits or strap bit do not match gets no acknowledge. No register changes before the next START.
- R4: A matching address with direction bit 1 gets no acknowledge. The target then leaves the line released and writes nothing until the next START.
- R5: The byte after the address selects the starting register. Every later byte is written to the register the pointer holds. Each such write gives exactly one wrStrobe cycle, with wrIndex set to that register. A register changes only in a strobe cycle.
- R6: After each data byte the pointer advances by one, so a burst fills consecutive registers.
- R7: The pointer wraps from register 4 to register 0. A longer burst overwrites the earliest registers.
- R8: A register-select value above 04h is still acknowledged. The data byte sent to it is acknowledged and dropped, with no strobe and no register change. The next data byte goes to register 0.
- R9: A STOP at any point, including inside a byte, returns the target to idle. A partial byte is never written, and the line stays released.
- R10: A repeated START inside a transfer restarts address reception. The byte in progress is dropped, and the transfer that follows works like a fresh one.
- R11: The register-select byte and every data byte of an addressed write are acknowledged. The pull-down is released while SCL is low after the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| strapBit | input | 1 | Strap that sets address bit 1 |
| sdaPullLow | output | 1 | 1 = drive the data line low |
| regFlat | output | NUM_REGS*8 | Register bank, register k at bits 8k+7..8k |
| wrStrobe | output | 1 | One-cycle pulse per register write |
| wrIndex | output | clog2(NUM_REGS) | Index of the register written |

## Verification
The data byte that lands in register 4 is committed on the same edge where the pointer wraps to 0 and where the acknowledge pull-down starts. Bursts that start at register 3 and register 4 are sent for that reason. The scoreboard expects the strobes to arrive with indices in the order 3, 4, 0, 1. The bench samples the data line during the ninth clock of that same byte to confirm that the acknowledge was given. A dropped byte sent to an out-of-range register is followed by a byte for register 0, so the discard and the wrap are judged in a single transfer.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftBit;
    logic loadPtr;
    logic commitData;
    logic pullSda;
  } ctrlStrobe_t;

  // observations from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic addrHit;
    logic readReq;
  } busEvent_t;

  typedef enum logic [1:0] {PH_IDLE, PH_RECV, PH_ACK, PH_HOLD} phase_t;
  typedef enum logic [1:0] {BK_ADDR, BK_SUB, BK_DATA} byteKind_t;

endpackage

// File: rtl/i2c_tgt_datapath.sv
module i2c_tgt_datapath
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter int SYNC_STAGES = 2,
  parameter logic [5:0] DEV_ADDR_HI = 6'b001000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic strapBit,
  input  ctrlStrobe_t ctrl,
  output busEvent_t evt,
  output logic [NUM_REGS*8-1:0] regFlat,
  output logic wrStrobe,
  output logic [$clog2(NUM_REGS)-1:0] wrIndex
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int LAST = NUM_REGS - 1;

  // synchronizer plus one extra stage holding the previous level
  logic [SYNC_STAGES:0] sclPipe, sdaPipe;
  logic sclNow, sclPrev, sdaNow, sdaPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-1:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-1:0], sdaIn};
    end
  end

  assign sclNow  = sclPipe[SYNC_STAGES-1];
  assign sclPrev = sclPipe[SYNC_STAGES];
  assign sdaNow  = sdaPipe[SYNC_STAGES-1];
  assign sdaPrev = sdaPipe[SYNC_STAGES];

  // byte shifter
  logic [7:0] shiftReg;
  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else if (ctrl.shiftBit) shiftReg <= {shiftReg[6:0], sdaNow};
  end

  always_comb begin
    evt.sclRise   = sclNow & ~sclPrev;
    evt.sclFall   = ~sclNow & sclPrev;
    evt.startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
    evt.stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
    evt.addrHit   = (shiftReg[7:1] == {DEV_ADDR_HI, strapBit});
    evt.readReq   = shiftReg[0];
  end

  // register pointer and bank
  logic [7:0] regPtr;
  logic [7:0] regBank [NUM_REGS];
  logic ptrValid;

  assign ptrValid = (regPtr < 8'(NUM_REGS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regPtr   <= '0;
      wrStrobe <= 1'b0;
      wrIndex  <= '0;
      for (int k = 0; k < NUM_REGS; k++) regBank[k] <= '0;
    end else begin
      wrStrobe <= 1'b0;
      if (ctrl.loadPtr) begin
        regPtr <= shiftReg;
      end else if (ctrl.commitData) begin
        if (ptrValid) begin
          regBank[regPtr[IDX_W-1:0]] <= shiftReg;
          wrStrobe <= 1'b1;
          wrIndex  <= regPtr[IDX_W-1:0];
        end
        regPtr <= (regPtr >= 8'(LAST)) ? 8'd0 : regPtr + 8'd1;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gOut
    assign regFlat[g*8 +: 8] = regBank[g];
  end

endmodule

// File: rtl/i2c_tgt_control.sv
module i2c_tgt_control
  import i2c_tgt_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  busEvent_t evt,
  output ctrlStrobe_t ctrl
);
  phase_t phase;
  byteKind_t kind;
  logic [3:0] bitCnt;
  logic byteDone, wantAck;

  always_comb begin
    byteDone = (phase == PH_RECV) && evt.sclFall && (bitCnt == 4'd8);
    wantAck  = (kind != BK_ADDR) || (evt.addrHit && !evt.readReq);
    ctrl.shiftBit   = (phase == PH_RECV) && evt.sclRise && (bitCnt < 4'd8);
    ctrl.loadPtr    = byteDone && (kind == BK_SUB);
    ctrl.commitData = byteDone && (kind == BK_DATA);
    ctrl.pullSda    = (phase == PH_ACK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      kind   <= BK_ADDR;
      bitCnt <= '0;
    end else if (evt.stopSeen) begin
      phase <= PH_IDLE;
    end else if (evt.startSeen) begin
      phase  <= PH_RECV;
      kind   <= BK_ADDR;
      bitCnt <= '0;
    end else begin
      case (phase)
        PH_RECV: begin
          if (ctrl.shiftBit) bitCnt <= bitCnt + 4'd1;
          if (byteDone) phase <= wantAck ? PH_ACK : PH_HOLD;
        end
        PH_ACK: begin
          if (evt.sclFall) begin
            phase  <= PH_RECV;
            bitCnt <= '0;
            kind   <= (kind == BK_ADDR) ? BK_SUB : BK_DATA;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter int SYNC_STAGES = 2,
  parameter logic [5:0] DEV_ADDR_HI = 6'b001000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic strapBit,
  output logic sdaPullLow,
  output logic [NUM_REGS*8-1:0] regFlat,
  output logic wrStrobe,
  output logic [$clog2(NUM_REGS)-1:0] wrIndex
);
  ctrlStrobe_t ctrl;
  busEvent_t evt;

  i2c_tgt_datapath #(
    .NUM_REGS(NUM_REGS), .SYNC_STAGES(SYNC_STAGES), .DEV_ADDR_HI(DEV_ADDR_HI)
  ) uData (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strapBit(strapBit),
    .ctrl(ctrl), .evt(evt), .regFlat(regFlat), .wrStrobe(wrStrobe), .wrIndex(wrIndex)
  );

  i2c_tgt_control uCtrl (
    .clk(clk), .rstN(rstN), .evt(evt), .ctrl(ctrl)
  );

  assign sdaPullLow = ctrl.pullSda;

endmodule

// File: rtl/i2c_wr_target_chk.sv
module i2c_wr_target_chk #(
  parameter int NUM_REGS = 5
) (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaPullLow,
  input logic [NUM_REGS*8-1:0] regFlat,
  input logic wrStrobe,
  input logic [$clog2(NUM_REGS)-1:0] wrIndex
);

  // R1: one cycle after reset is seen, bank cleared and line released
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (regFlat == '0) && !sdaPullLow && !wrStrobe);

  // R2: pull-down starts only while the serial clock is low
  p_ack_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclIn);

  // R11: pull-down ends only while the serial clock is low
  p_ack_end_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> !sclIn);

  // R5: bank changes only together with a strobe
  p_reg_change_strobed_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regFlat) |-> wrStrobe);

  // R5: strobe lasts a single cycle
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R8: strobe never names a register outside the bank
  p_index_in_bank_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (32'(wrIndex) < NUM_REGS));

endmodule

bind i2c_wr_target i2c_wr_target_chk #(.NUM_REGS(NUM_REGS)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .regFlat(regFlat), .wrStrobe(wrStrobe), .wrIndex(wrIndex)
);

// File: tb/i2c_wr_target_test.sv
module i2c_wr_target_test;
  localparam int NREG = 5;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic strapBit = 1'b1;
  logic sdaPullLow, wrStrobe;
  logic [NREG*8-1:0] regFlat;
  logic [2:0] wrIndex;
  logic sdaBus;

  assign sdaBus = sdaM & ~sdaPullLow;

  always #5 clk = ~clk;

  i2c_wr_target uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .strapBit(strapBit),
    .sdaPullLow(sdaPullLow), .regFlat(regFlat), .wrStrobe(wrStrobe), .wrIndex(wrIndex)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] expRegs [NREG];
  int tbPtr = 0;
  logic [10:0] expQ [$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; qwait();
    sclM = 1'b1; qwait();
    sdaM = 1'b0; qwait();
    sclM = 1'b0; qwait();
  endtask

  task automatic stopCond();
    sdaM = 1'b0; qwait();
    sclM = 1'b1; qwait();
    sdaM = 1'b1; qwait();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; qwait();
    sclM = 1'b1; qwait(); qwait();
    sclM = 1'b0; qwait();
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string req);
    bit ack;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; qwait();
    sclM = 1'b1; qwait();
    ack = !sdaBus;
    check(ack == expAck, req, "acknowledge", int'(ack), int'(expAck));
    qwait();
    sclM = 1'b0; qwait();
    check(sdaPullLow == 1'b0, "R11", "release after ninth clock", int'(sdaPullLow), 0);
  endtask

  // bench-side model of the pointer
  task automatic putSub(input logic [7:0] s, input string req);
    sendByte(s, 1'b1, req);
    tbPtr = int'(s);
  endtask

  task automatic putData(input logic [7:0] d, input string req);
    if (tbPtr < NREG) begin
      expQ.push_back({3'(tbPtr), d});
      expRegs[tbPtr] = d;
    end
    sendByte(d, 1'b1, req);
    tbPtr = (tbPtr >= NREG - 1) ? 0 : tbPtr + 1;
  endtask

  task automatic checkBank(input string req);
    for (int k = 0; k < NREG; k++)
      check(regFlat[k*8 +: 8] == expRegs[k], req, $sformatf("register %0d", k),
            int'(regFlat[k*8 +: 8]), int'(expRegs[k]));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && wrStrobe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5", "unexpected strobe index", int'(wrIndex), -1);
      end else begin
        logic [10:0] e;
        e = expQ.pop_front();
        check(wrIndex == e[10:8], "R6", "strobe index", int'(wrIndex), int'(e[10:8]));
        check(regFlat[int'(wrIndex)*8 +: 8] == e[7:0], "R5", "written data",
              int'(regFlat[int'(wrIndex)*8 +: 8]), int'(e[7:0]));
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    for (int k = 0; k < NREG; k++) expRegs[k] = 8'h00;
    repeat (5) @(negedge clk);
    check(regFlat == '0, "R1", "bank after reset", int'(regFlat[31:0]), 0);
    check(sdaPullLow == 1'b0, "R1", "line released in reset", int'(sdaPullLow), 0);
    check(wrStrobe == 1'b0, "R1", "no strobe in reset", int'(wrStrobe), 0);
    rstN = 1'b1;
    qwait();

    // R5 R6: simple burst
    startCond();
    sendByte(8'h22, 1'b1, "R2");
    putSub(8'h01, "R11");
    putData(8'hA1, "R5");
    putData(8'hB2, "R6");
    stopCond();
    checkBank("R6");

    // R7: burst across the wrap point
    startCond();
    sendByte(8'h22, 1'b1, "R2");
    putSub(8'h03, "R11");
    putData(8'h11, "R7");
    putData(8'h22, "R7");
    putData(8'h33, "R7");
    putData(8'h44, "R7");
    stopCond();
    checkBank("R7");

    // R4: read request rejected, later bytes ignored
    startCond();
    sendByte(8'h23, 1'b0, "R4");
    sendByte(8'h00, 1'b0, "R4");
    sendByte(8'h55, 1'b0, "R4");
    stopCond();
    checkBank("R4");

    // R3: wrong strap bit, then wrong fixed bits
    startCond();
    sendByte(8'h20, 1'b0, "R3");
    sendByte(8'h00, 1'b0, "R3");
    sendByte(8'h66, 1'b0, "R3");
    stopCond();
    startCond();
    sendByte(8'h62, 1'b0, "R3");
    sendByte(8'h01, 1'b0, "R3");
    stopCond();
    checkBank("R3");

    // R8: out-of-range register select, discard then wrap to 0
    startCond();
    sendByte(8'h22, 1'b1, "R2");
    putSub(8'h07, "R8");
    putData(8'h77, "R8");
    putData(8'h88, "R8");
    stopCond();
    checkBank("R8");

    // R9: stop inside a data byte
    startCond();
    sendByte(8'h22, 1'b1, "R2");
    putSub(8'h02, "R11");
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    stopCond();
    repeat (8) @(negedge clk);
    check(sdaPullLow == 1'b0, "R9", "line released after stop", int'(sdaPullLow), 0);
    checkBank("R9");
    startCond();
    sendByte(8'h22, 1'b1, "R9");
    putSub(8'h02, "R9");
    putData(8'h99, "R9");
    stopCond();

    // R10: repeated start inside a data byte
    startCond();
    sendByte(8'h22, 1'b1, "R2");
    putSub(8'h00, "R11");
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1); sendBit(1'b0);
    startCond();
    sendByte(8'h22, 1'b1, "R10");
    putSub(8'h04, "R10");
    putData(8'hAB, "R10");
    stopCond();
    repeat (8) @(negedge clk);
    checkBank("R10");
    check(expQ.size() == 0, "R5", "pending expected writes", expQ.size(), 0);

    finishRun();
  end

endmodule